// File: doc/BRIEF.md
# Paged Host Window into Dual-Port RAM

This block gives two agents a shared 1 KB memory. The first agent is a small satellite processor that takes all of its memory from this RAM. It sees the array directly at addresses $0000-$03FF of its 16-bit address space. The second agent is a host 8-bit system bus. The host owns a 32-byte I/O block. Offset $00 holds a 6-bit page register. Offsets $10-$1F form a 16-byte window onto the RAM. The host picks which 16-byte slice the window shows by loading the page register. It then reads and writes through the window, so it reaches the whole array in slices.

Both sides use a plain synchronous strobe interface on one clock. Each side has a read strobe, a write strobe, an address and write data. The host side also has a chip select. Read data appears one clock after the read strobe and holds until the next read on that side. There is no back-pressure and no handshake: every strobe is accepted in the cycle it is presented. The page register and the read-data registers reset. The RAM contents do not.

Top module: `hpw_top`

## Requirements
- R1: A satellite write with address below $0400 stores the data at RAM byte address[9:0]. A satellite read strobe in cycle N shows that byte on `sat_rdata` after the clock edge that ends cycle N.
- R2: A satellite access with address $0400 or higher does not touch the RAM. A read of such an address returns $FF one cycle later. A write to it changes no RAM byte.
- R3: A host access with chip select high and offset $10-$1F (offset bit 4 set) reaches the RAM byte at {page[5:0], offset[3:0]}. Host window reads have one cycle of latency, like satellite reads.
- R4: A host write to offset $00 loads the page register from write-data bits [5:0]. A host read of offset $00 returns {2'b00, page} one cycle later.
- R5: After reset the page register is 0. Both read-data outputs are $00.
- R6: Host offsets $01-$0F read as $00 and ignore writes. Such a write changes neither the page register nor any RAM byte.
- R7: Each read-data output changes only after a read strobe on its own side. It holds its value through idle cycles and write cycles.
- R8: When both sides write the same RAM byte in the same cycle, the satellite's data is stored.
- R9: A read in the same cycle as a write to the same byte, from either side, returns the byte's old contents.
- R10: With the host chip select low, the host strobes have no effect. The page register, the RAM and `host_rdata` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| sat_addr | input | 16 | Satellite address |
| sat_rd | input | 1 | Satellite read strobe |
| sat_wr | input | 1 | Satellite write strobe |
| sat_wdata | input | 8 | Satellite write data |
| sat_rdata | output | 8 | Satellite read data, one cycle after the read strobe |
| host_cs | input | 1 | Host chip select for the 32-byte I/O block |
| host_addr | input | 5 | Host offset within the I/O block |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one cycle after the read strobe |

## Verification
The embedded properties check several behaviours on every cycle:
- the $FF return for satellite addresses above the array;
- the zero upper bits on page reads and the all-zero reads of unused offsets;
- that the page register stays put on unused-offset writes and when the host is deselected;
- that the satellite wins a same-byte write collision.

Other behaviours need the bench's reference memory and only its scenarios can show them:
- that a window access lands on {page, offset} in the array;
- that same-cycle reads return the old contents;
- that stray writes to the hole above $03FF or to unused offsets leave the array intact.

// File: rtl/hpw_pkg.sv
package hpw_pkg;
  localparam int RAM_AW   = 10;  // 1 KB shared array
  localparam int DATA_W   = 8;
  localparam int SAT_AW   = 16;  // satellite address space
  localparam int WIN_AW   = 4;   // 16-byte host window
  localparam int HOST_OFS_W = WIN_AW + 1;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_PAGE = 2'd1,
    SRC_RAM  = 2'd2
  } host_src_e;
endpackage

// File: rtl/hpw_dpram.sv
// Two-port array, one clock. Read-first on both ports; port A wins a
// same-address write collision because its store is applied last.
module hpw_dpram #(
  parameter int AW = hpw_pkg::RAM_AW,
  parameter int DW = hpw_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_re,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_q,
  input  logic          b_re,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wdata;
    if (a_we) mem[a_addr] <= a_wdata;  // later store: port A priority
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (a_re) a_q <= mem[a_addr];
      if (b_re) b_q <= mem[b_addr];
    end
  end
endmodule

// File: rtl/hpw_sat_port.sv
// Satellite decode: the array occupies the bottom of the address space,
// everything above it reads as all ones.
module hpw_sat_port #(
  parameter int SAW = hpw_pkg::SAT_AW,
  parameter int AW  = hpw_pkg::RAM_AW,
  parameter int DW  = hpw_pkg::DATA_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SAW-1:0] addr,
  input  logic           rd,
  input  logic           wr,
  output logic           ram_re,
  output logic           ram_we,
  output logic [AW-1:0]  ram_addr,
  input  logic [DW-1:0]  ram_q,
  output logic [DW-1:0]  rdata
);
  logic in_array;
  logic hit_q;

  assign in_array = (addr[SAW-1:AW] == '0);
  assign ram_re   = rd & in_array;
  assign ram_we   = wr & in_array;
  assign ram_addr = addr[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)  hit_q <= 1'b1;
    else if (rd) hit_q <= in_array;
  end

  assign rdata = hit_q ? ram_q : '1;

  a_r2_hole_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr >= SAW'(1 << AW)) |=> (rdata == '1));
endmodule

// File: rtl/hpw_host_window.sv
// Host I/O block: page register at offset 0, unused offsets 1..15,
// RAM window at offsets 16..31.
module hpw_host_window #(
  parameter int AW  = hpw_pkg::RAM_AW,
  parameter int DW  = hpw_pkg::DATA_W,
  parameter int WAW = hpw_pkg::WIN_AW,
  localparam int OFS_W  = WAW + 1,
  localparam int PAGE_W = AW - WAW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic [OFS_W-1:0] addr,
  input  logic             rd,
  input  logic             wr,
  input  logic [DW-1:0]    wdata,
  output logic             ram_re,
  output logic             ram_we,
  output logic [AW-1:0]    ram_addr,
  input  logic [DW-1:0]    ram_q,
  output logic [DW-1:0]    rdata,
  output logic [PAGE_W-1:0] page
);
  import hpw_pkg::*;

  logic win_sel, page_sel;
  logic [PAGE_W-1:0] page_snap;
  host_src_e src_q;
  logic unused_wdata_hi;

  assign win_sel  = cs & addr[OFS_W-1];
  assign page_sel = cs & (addr == '0);
  assign ram_re   = win_sel & rd;
  assign ram_we   = win_sel & wr;
  assign ram_addr = {page, addr[WAW-1:0]};
  assign unused_wdata_hi = ^wdata[DW-1:PAGE_W];

  always_ff @(posedge clk) begin
    if (!rst_n)             page <= '0;
    else if (page_sel & wr) page <= wdata[PAGE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q     <= SRC_ZERO;
      page_snap <= '0;
    end else if (cs & rd) begin
      page_snap <= page;
      if (win_sel)       src_q <= SRC_RAM;
      else if (page_sel) src_q <= SRC_PAGE;
      else               src_q <= SRC_ZERO;
    end
  end

  always_comb begin
    case (src_q)
      SRC_RAM:  rdata = ram_q;
      SRC_PAGE: rdata = {{(DW-PAGE_W){1'b0}}, page_snap};
      default:  rdata = '0;
    endcase
  end

  a_r4_page_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && addr == '0) |=> (rdata[DW-1:PAGE_W] == '0));
  a_r6_unused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && addr != '0 && !addr[OFS_W-1]) |=> (rdata == '0));
  a_r6_unused_write_keeps_page: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr != '0) |=> $stable(page));
  a_r10_deselect_keeps_page: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs) |=> $stable(page));
endmodule

// File: rtl/hpw_top.sv
module hpw_top #(
  parameter int RAM_AW = hpw_pkg::RAM_AW,
  parameter int DATA_W = hpw_pkg::DATA_W,
  parameter int SAT_AW = hpw_pkg::SAT_AW,
  parameter int WIN_AW = hpw_pkg::WIN_AW,
  localparam int OFS_W  = WIN_AW + 1,
  localparam int PAGE_W = RAM_AW - WIN_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SAT_AW-1:0] sat_addr,
  input  logic              sat_rd,
  input  logic              sat_wr,
  input  logic [DATA_W-1:0] sat_wdata,
  output logic [DATA_W-1:0] sat_rdata,
  input  logic              host_cs,
  input  logic [OFS_W-1:0]  host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata
);
  logic              s_re, s_we, h_re, h_we;
  logic [RAM_AW-1:0] s_addr, h_addr;
  logic [DATA_W-1:0] s_q, h_q;
  logic [PAGE_W-1:0] page;

  hpw_sat_port #(.SAW(SAT_AW), .AW(RAM_AW), .DW(DATA_W)) u_sat (
    .clk(clk), .rst_n(rst_n), .addr(sat_addr), .rd(sat_rd), .wr(sat_wr),
    .ram_re(s_re), .ram_we(s_we), .ram_addr(s_addr), .ram_q(s_q),
    .rdata(sat_rdata)
  );

  hpw_host_window #(.AW(RAM_AW), .DW(DATA_W), .WAW(WIN_AW)) u_host (
    .clk(clk), .rst_n(rst_n), .cs(host_cs), .addr(host_addr), .rd(host_rd),
    .wr(host_wr), .wdata(host_wdata), .ram_re(h_re), .ram_we(h_we),
    .ram_addr(h_addr), .ram_q(h_q), .rdata(host_rdata), .page(page)
  );

  hpw_dpram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .a_re(s_re), .a_we(s_we), .a_addr(s_addr), .a_wdata(sat_wdata), .a_q(s_q),
    .b_re(h_re), .b_we(h_we), .b_addr(h_addr), .b_wdata(host_wdata), .b_q(h_q)
  );

  // Same-byte double write, checked through a follow-up satellite read.
  logic collide;
  assign collide = sat_wr && (sat_addr < SAT_AW'(1 << RAM_AW)) &&
                   host_cs && host_wr && host_addr[OFS_W-1] &&
                   ({page, host_addr[WIN_AW-1:0]} == sat_addr[RAM_AW-1:0]);

  a_r8_sat_wins: assert property (@(posedge clk) disable iff (!rst_n)
    collide ##1 (sat_rd && !sat_wr && !host_wr && sat_addr == $past(sat_addr))
    |=> (sat_rdata == $past(sat_wdata, 2)));
endmodule

// File: tb/hpw_top_test.sv
`timescale 1ns/1ps
module hpw_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] sat_addr = '0;
  logic sat_rd = 1'b0, sat_wr = 1'b0;
  logic [7:0] sat_wdata = '0;
  logic [7:0] sat_rdata;
  logic host_cs = 1'b0;
  logic [4:0] host_addr = '0;
  logic host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;

  always #2.5 clk = ~clk;

  hpw_top uut (
    .clk(clk), .rst_n(rst_n), .sat_addr(sat_addr), .sat_rd(sat_rd),
    .sat_wr(sat_wr), .sat_wdata(sat_wdata), .sat_rdata(sat_rdata),
    .host_cs(host_cs), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  int checks = 0;
  int fails = 0;

  // Behavioural reference
  int mem [1024];
  int page = 0;
  int e_sat = 0;
  int e_host = 0;

  task automatic check(string req, int got, int exp, string what);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  // One clock: drive at negedge, update the model after the edge,
  // compare both outputs at the next negedge.
  task automatic cyc(string req, int sa, bit srd, bit swr, int swd,
                     bit hcs, int ha, bit hrd, bit hwr, int hwd);
    int widx;
    sat_addr = 16'(sa); sat_rd = srd; sat_wr = swr; sat_wdata = 8'(swd);
    host_cs = hcs; host_addr = 5'(ha); host_rd = hrd; host_wr = hwr;
    host_wdata = 8'(hwd);
    @(posedge clk);
    #1;
    widx = page * 16 + (ha % 16);
    if (srd) e_sat = (sa < 1024) ? mem[sa] : 255;
    if (hcs && hrd) e_host = (ha >= 16) ? mem[widx] : (ha == 0) ? page : 0;
    if (hcs && hwr) begin
      if (ha >= 16) mem[widx] = hwd & 255;
      else if (ha == 0) page = hwd & 63;
    end
    if (swr && sa < 1024) mem[sa] = swd & 255;
    @(negedge clk);
    check(req, int'(sat_rdata), e_sat, "sat_rdata");
    check(req, int'(host_rdata), e_host, "host_rdata");
  endtask

  task automatic idle(string req);
    cyc(req, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic sat_w(string req, int a, int d);
    cyc(req, a, 0, 1, d, 0, 0, 0, 0, 0);
  endtask
  task automatic sat_r(string req, int a);
    cyc(req, a, 1, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic host_w(string req, int a, int d);
    cyc(req, 0, 0, 0, 0, 1, a, 0, 1, d);
  endtask
  task automatic host_r(string req, int a);
    cyc(req, 0, 0, 0, 0, 1, a, 1, 0, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R5: reset state
    check("R5", int'(sat_rdata), 0, "sat_rdata after reset");
    check("R5", int'(host_rdata), 0, "host_rdata after reset");
    host_r("R5", 0);
    check("R5", int'(host_rdata), 0, "page after reset");

    // R1: fill the array from the satellite side, read samples back
    for (int i = 0; i < 1024; i++) sat_w("R1", i, (i * 7 + 3) & 255);
    for (int i = 0; i < 1024; i += 37) sat_r("R1", i);
    sat_r("R1", 1023);

    // R2: hole above the array
    sat_r("R2", 16'h0400);
    check("R2", int'(sat_rdata), 255, "hole read");
    sat_r("R2", 16'hFFFF);
    sat_w("R2", 16'h0405, 8'h5A);
    sat_w("R2", 16'h8000, 8'hA5);
    host_w("R2", 0, 0);
    host_r("R2", 16 + 5);
    check("R2", int'(host_rdata), (5 * 7 + 3) & 255, "alias byte untouched");
    sat_r("R2", 0);
    check("R2", int'(sat_rdata), 3, "byte 0 untouched");

    // R4: page register, upper bits dropped
    host_w("R4", 0, 8'hFF);
    host_r("R4", 0);
    check("R4", int'(host_rdata), 8'h3F, "page readback");
    host_w("R4", 0, 8'h45);
    host_r("R4", 0);
    check("R4", int'(host_rdata), 8'h05, "page readback");

    // R3: window reads and writes on several pages
    for (int p = 0; p < 64; p += 21) begin
      host_w("R3", 0, p);
      for (int o = 16; o < 32; o++) host_r("R3", o);
      host_w("R3", 16 + (p % 16), 8'hC0 + p);
      sat_r("R3", p * 16 + (p % 16));
      check("R3", int'(sat_rdata), (8'hC0 + p) & 255, "host write seen by satellite");
    end

    // R6: unused offsets
    host_w("R6", 0, 9);
    for (int o = 1; o < 16; o++) host_w("R6", o, 8'hAA);
    host_r("R6", 0);
    check("R6", int'(host_rdata), 9, "page after unused writes");
    for (int o = 1; o < 16; o++) host_r("R6", o);
    check("R6", int'(host_rdata), 0, "unused read");
    for (int o = 16; o < 32; o++) host_r("R6", o);

    // R7: outputs hold through idle and write cycles
    sat_r("R7", 100);
    host_r("R7", 17);
    idle("R7"); idle("R7");
    sat_w("R7", 100, 8'h11);
    host_w("R7", 17, 8'h22);
    check("R7", int'(sat_rdata), (100 * 7 + 3) & 255, "sat hold");

    // R8: same-byte double write, satellite wins
    host_w("R8", 0, 12);
    cyc("R8", 12 * 16 + 7, 0, 1, 8'h3C, 1, 16 + 7, 0, 1, 8'hC3);
    sat_r("R8", 12 * 16 + 7);
    check("R8", int'(sat_rdata), 8'h3C, "collision winner");
    host_r("R8", 16 + 7);

    // R9: read-first on both sides
    sat_w("R9", 12 * 16 + 2, 8'h71);
    cyc("R9", 12 * 16 + 2, 1, 0, 0, 1, 16 + 2, 0, 1, 8'h99);
    check("R9", int'(sat_rdata), 8'h71, "sat old data");
    cyc("R9", 12 * 16 + 2, 0, 1, 8'h44, 1, 16 + 2, 1, 0, 0);
    check("R9", int'(host_rdata), 8'h99, "host old data");
    sat_r("R9", 12 * 16 + 2);
    check("R9", int'(sat_rdata), 8'h44, "new data after");

    // R10: deselected host strobes do nothing
    host_r("R10", 0);
    cyc("R10", 0, 0, 0, 0, 0, 0, 0, 1, 8'h3F);
    cyc("R10", 0, 0, 0, 0, 0, 16 + 3, 1, 1, 8'hEE);
    check("R10", int'(host_rdata), 12, "hold when deselected");
    host_r("R10", 0);
    check("R10", int'(host_rdata), 12, "page after deselected write");
    host_r("R10", 16 + 3);

    // Mixed traffic on both sides
    for (int n = 0; n < 3000; n++) begin
      int sa;
      int ha;
      sa = ($urandom % 8 == 0) ? int'($urandom % 65536) : int'($urandom % 1024);
      ha = int'($urandom % 32);
      cyc("R3", sa, 1'($urandom), 1'($urandom), int'($urandom % 256),
          1'($urandom), ha, 1'($urandom), 1'($urandom), int'($urandom % 256));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule